// File: doc/BRIEF.md
# Extended Multiply-Divide Unit

A multi-cycle arithmetic engine that serves a 16-bit core. It provides four operations: a signed 16/16 divide, an unsigned 32/16 divide, a signed 32/16 divide, and a signed 16x16 multiply. The core presents its D, X and Y register values and an operation code, then pulses `start_i`. The unit captures its operands on that edge and works without further input. It then returns replacement register values with per-register write enables, plus Z, N, V and C flag values with per-flag enables, all during a single `done_o` cycle.

Division runs a restoring shift-subtract loop that produces one quotient bit per clock. Signed forms divide magnitudes and then fix the signs. The quotient truncates toward zero, and the remainder carries the sign of the dividend. The multiply finishes in one working cycle.

Top module: `mdu_top`

## Requirements
- R1: Op 0 (signed divide) divides D by X, both as signed 16-bit values. The quotient is written to X and the remainder to D, and Y is not written. The quotient truncates toward zero, and the remainder has the sign of D.
- R2: Op 1 (unsigned wide divide) divides the unsigned 32-bit value {Y,D} by unsigned X. The low 16 quotient bits are written to Y and the remainder to D, and X is not written.
- R3: Op 2 (signed wide divide) divides the signed 32-bit value {Y,D} by signed 16-bit X. The low 16 quotient bits are written to Y and the remainder to D, and X is not written. Truncation and remainder sign follow R1.
- R4: For ops 0 and 2, V is set exactly when the signed quotient lies outside -32768..32767.
- R5: For op 1, V is set exactly when the quotient needs more than 16 bits.
- R6: For ops 0 to 2, a zero X sets C and enables only the C flag (flags_we_o = 4'b0001), and no register write enable is raised.
- R7: For a divide with a nonzero divisor, all four flags are enabled. C is 0, Z is 1 when the quotient is zero, and N is quotient bit 15. Flag bit positions are Z=3, N=2, V=1, C=0.
- R8: Op 3 (signed multiply) forms D*Y as signed 16-bit values. The low 16 bits are written to D and the high 16 bits to Y, and X is not written.
- R9: For op 3, Z, N and C are enabled (flags_we_o = 4'b1101) with Z = (product == 0), N = product bit 31, C = product bit 15, and V is not enabled.
- R10: When start_i is sampled high in idle at edge k, done_o is high in the cycle after edge k+33 for a divide with a nonzero divisor, and after edge k+1 otherwise.
- R11: busy_o is high from the edge after acceptance until the done cycle, and start_i is ignored while busy_o is high.
- R12: done_o is a one-cycle pulse. Write enables and flag enables are high only together with done_o, and any flag bit that is not enabled reads 0.
- R13: After reset, busy_o, done_o, all enables and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 2 | Operation: 0 signed div, 1 unsigned wide div, 2 signed wide div, 3 signed mul |
| d_i | input | 16 | D register value |
| x_i | input | 16 | X register value |
| y_i | input | 16 | Y register value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| d_o | output | 16 | New D value |
| x_o | output | 16 | New X value |
| y_o | output | 16 | New Y value |
| d_we_o | output | 1 | Write enable for D |
| x_we_o | output | 1 | Write enable for X |
| y_we_o | output | 1 | Write enable for Y |
| flags_o | output | 4 | Flag values {Z,N,V,C} |
| flags_we_o | output | 4 | Flag enables {Z,N,V,C} |

## Verification
The bench focuses on sign corners. Negative dividends and divisors catch a design that floors instead of truncating, or that gives the remainder the divisor's sign. -32768/-1 and -2^31/-1 catch a magnitude path one bit too narrow, which would report a wrong quotient or miss V. Quotients of exactly 32768 and -32768 probe the asymmetric signed overflow bound, where an off-by-one comparator flags or misses V. A zero divisor must leave every register untouched, so a design that writes garbage would raise an enable. A start pulse issued mid-operation must not disturb the result or the latency, which an unguarded start would restart.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_SDIV  = 2'd0,
    OP_UDIVX = 2'd1,
    OP_SDIVX = 2'd2,
    OP_SMUL  = 2'd3
  } mdu_op_e;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_N = 2;
  localparam int FLG_Z = 3;
  localparam int NFLG  = 4;
endpackage

// File: rtl/mdu_prep.sv
`timescale 1ns/1ps
module mdu_prep
  import mdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  mdu_op_e         op_i,
  input  logic [DW-1:0]   d_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  output logic [2*DW-1:0] dvd_mag_o,
  output logic [DW-1:0]   dvs_mag_o,
  output logic            q_neg_o,
  output logic            r_neg_o,
  output logic            dvs_zero_o
);
  localparam int WW = 2 * DW;

  logic            is_signed;
  logic [WW-1:0]   dvd;
  logic            dvd_neg;
  logic            dvs_neg;

  always_comb begin
    is_signed  = (op_i != OP_UDIVX);
    // narrow divide sign-extends D into the wide dividend
    dvd        = (op_i == OP_SDIV) ? {{DW{d_i[DW-1]}}, d_i} : {y_i, d_i};
    dvd_neg    = is_signed & dvd[WW-1];
    dvs_neg    = is_signed & x_i[DW-1];
    dvd_mag_o  = dvd_neg ? -dvd : dvd;
    dvs_mag_o  = dvs_neg ? -x_i : x_i;
    q_neg_o    = dvd_neg ^ dvs_neg;
    r_neg_o    = dvd_neg;
    dvs_zero_o = (x_i == '0);
  end
endmodule

// File: rtl/mdu_div_core.sv
`timescale 1ns/1ps
module mdu_div_core #(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [2*DW-1:0] dvd_i,
  input  logic [DW-1:0]   dvs_i,
  output logic [2*DW-1:0] quo_o,
  output logic [DW-1:0]   rem_o
);
  localparam int WW = 2 * DW;

  logic [WW-1:0] acc_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] dvs_q;
  logic [DW:0]   trial;
  logic [DW-1:0] diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, acc_q[WW-1]};
    fits  = (trial >= {1'b0, dvs_q});
    diff  = trial[DW-1:0] - dvs_q;  // exact when fits: result < 2^DW
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      acc_q <= dvd_i;
      rem_q <= '0;
      dvs_q <= dvs_i;
    end else if (step_i) begin
      acc_q <= {acc_q[WW-2:0], fits};
      rem_q <= fits ? diff : trial[DW-1:0];
    end
  end

  assign quo_o = acc_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/mdu_result.sv
`timescale 1ns/1ps
module mdu_result
  import mdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  mdu_op_e         op_i,
  input  logic            dvs_zero_i,
  input  logic            q_neg_i,
  input  logic            r_neg_i,
  input  logic [2*DW-1:0] quo_i,
  input  logic [DW-1:0]   rem_i,
  input  logic [2*DW-1:0] prod_i,
  output logic [DW-1:0]   d_o,
  output logic [DW-1:0]   x_o,
  output logic [DW-1:0]   y_o,
  output logic            d_we_o,
  output logic            x_we_o,
  output logic            y_we_o,
  output logic [NFLG-1:0] flags_o,
  output logic [NFLG-1:0] flags_we_o
);
  localparam int WW = 2 * DW;
  localparam logic [WW-1:0] POS_LIM = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [WW-1:0] NEG_LIM = POS_LIM + 1'b1;

  logic [DW-1:0] quo_s;
  logic [DW-1:0] rem_s;
  logic          ovf_s;
  logic          ovf_u;

  always_comb begin
    quo_s      = q_neg_i ? -quo_i[DW-1:0] : quo_i[DW-1:0];
    rem_s      = r_neg_i ? -rem_i : rem_i;
    ovf_s      = q_neg_i ? (quo_i > NEG_LIM) : (quo_i > POS_LIM);
    ovf_u      = |quo_i[WW-1:DW];
    d_o        = '0;
    x_o        = '0;
    y_o        = '0;
    d_we_o     = 1'b0;
    x_we_o     = 1'b0;
    y_we_o     = 1'b0;
    flags_o    = '0;
    flags_we_o = '0;
    if (op_i == OP_SMUL) begin
      d_o               = prod_i[DW-1:0];
      y_o               = prod_i[WW-1:DW];
      d_we_o            = 1'b1;
      y_we_o            = 1'b1;
      flags_o[FLG_Z]    = (prod_i == '0);
      flags_o[FLG_N]    = prod_i[WW-1];
      flags_o[FLG_C]    = prod_i[DW-1];
      flags_we_o[FLG_Z] = 1'b1;
      flags_we_o[FLG_N] = 1'b1;
      flags_we_o[FLG_C] = 1'b1;
    end else if (dvs_zero_i) begin
      flags_o[FLG_C]    = 1'b1;
      flags_we_o[FLG_C] = 1'b1;
    end else begin
      d_o            = rem_s;
      d_we_o         = 1'b1;
      if (op_i == OP_SDIV) begin
        x_o    = quo_s;
        x_we_o = 1'b1;
      end else begin
        y_o    = quo_s;
        y_we_o = 1'b1;
      end
      flags_o[FLG_Z] = (quo_i == '0);
      flags_o[FLG_N] = quo_s[DW-1];
      flags_o[FLG_V] = (op_i == OP_UDIVX) ? ovf_u : ovf_s;
      flags_we_o     = '1;
    end
  end
endmodule

// File: rtl/mdu_top.sv
`timescale 1ns/1ps
module mdu_top
  import mdu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] d_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic          d_we_o,
  output logic          x_we_o,
  output logic          y_we_o,
  output logic [3:0]    flags_o,
  output logic [3:0]    flags_we_o
);
  localparam int WW = 2 * DW;
  localparam int CW = $clog2(WW);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  mdu_op_e       op_in;
  mdu_op_e       op_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] y_q;
  logic          q_neg_q, r_neg_q, zero_q;
  logic          accept;

  logic [WW-1:0] dvd_mag;
  logic [DW-1:0] dvs_mag;
  logic          q_neg, r_neg, dvs_zero;
  logic [WW-1:0] quo;
  logic [DW-1:0] rem;
  logic [WW-1:0] prod;

  logic [DW-1:0]   res_d, res_x, res_y;
  logic            res_dwe, res_xwe, res_ywe;
  logic [NFLG-1:0] res_flg, res_fwe;

  assign op_in  = mdu_op_e'(op_i);
  assign accept = start_i && (st_q == S_IDLE);
  assign busy_o = (st_q != S_IDLE);
  assign prod   = $signed({{DW{d_q[DW-1]}}, d_q}) * $signed({{DW{y_q[DW-1]}}, y_q});

  mdu_prep #(.DW(DW)) i_prep (
    .op_i      (op_in),
    .d_i       (d_i),
    .x_i       (x_i),
    .y_i       (y_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .q_neg_o   (q_neg),
    .r_neg_o   (r_neg),
    .dvs_zero_o(dvs_zero)
  );

  mdu_div_core #(.DW(DW)) i_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .step_i(st_q == S_DIV),
    .dvd_i (dvd_mag),
    .dvs_i (dvs_mag),
    .quo_o (quo),
    .rem_o (rem)
  );

  mdu_result #(.DW(DW)) i_result (
    .op_i      (op_q),
    .dvs_zero_i(zero_q),
    .q_neg_i   (q_neg_q),
    .r_neg_i   (r_neg_q),
    .quo_i     (quo),
    .rem_i     (rem),
    .prod_i    (prod),
    .d_o       (res_d),
    .x_o       (res_x),
    .y_o       (res_y),
    .d_we_o    (res_dwe),
    .x_we_o    (res_xwe),
    .y_we_o    (res_ywe),
    .flags_o   (res_flg),
    .flags_we_o(res_fwe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      op_q       <= OP_SDIV;
      d_q        <= '0;
      y_q        <= '0;
      q_neg_q    <= 1'b0;
      r_neg_q    <= 1'b0;
      zero_q     <= 1'b0;
      done_o     <= 1'b0;
      d_o        <= '0;
      x_o        <= '0;
      y_o        <= '0;
      d_we_o     <= 1'b0;
      x_we_o     <= 1'b0;
      y_we_o     <= 1'b0;
      flags_o    <= '0;
      flags_we_o <= '0;
    end else begin
      done_o     <= 1'b0;
      d_we_o     <= 1'b0;
      x_we_o     <= 1'b0;
      y_we_o     <= 1'b0;
      flags_we_o <= '0;
      flags_o    <= '0;
      case (st_q)
        S_IDLE: if (accept) begin
          op_q    <= op_in;
          d_q     <= d_i;
          y_q     <= y_i;
          q_neg_q <= q_neg;
          r_neg_q <= r_neg;
          zero_q  <= dvs_zero;
          cnt_q   <= '0;
          st_q    <= (op_in == OP_SMUL || dvs_zero) ? S_FIN : S_DIV;
        end
        S_DIV: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(WW - 1)) st_q <= S_FIN;
        end
        S_FIN: begin
          done_o     <= 1'b1;
          d_o        <= res_d;
          x_o        <= res_x;
          y_o        <= res_y;
          d_we_o     <= res_dwe;
          x_we_o     <= res_xwe;
          y_we_o     <= res_ywe;
          flags_o    <= res_flg;
          flags_we_o <= res_fwe;
          st_q       <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdu_chk.sv
`timescale 1ns/1ps
module mdu_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic [DW-1:0] x_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          d_we_o,
  input logic          x_we_o,
  input logic          y_we_o,
  input logic [3:0]    flags_o,
  input logic [3:0]    flags_we_o
);
  logic [1:0] cap_op;
  logic       cap_zero;
  logic [7:0] cyc;
  logic       long_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_op   <= '0;
      cap_zero <= 1'b0;
      cyc      <= '0;
    end else if (start_i && !busy_o) begin
      cap_op   <= op_i;
      cap_zero <= (x_i == '0);
      cyc      <= 8'd1;
    end else if (busy_o && cyc != 8'hFF) begin
      cyc <= cyc + 8'd1;
    end
  end

  assign long_op = (cap_op != 2'd3) && !cap_zero;

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_we_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we_o || x_we_o || y_we_o || (|flags_we_o)) |-> done_o);
  a_r12_flags_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((flags_o & ~flags_we_o) == 4'b0000));
  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc == (long_op ? 8'(2*DW+2) : 8'd2)));
  a_r11_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r11_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r6_zero_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op != 2'd3 && cap_zero) |->
      (flags_we_o == 4'b0001 && flags_o[0] && !d_we_o && !x_we_o && !y_we_o));
  a_r9_mul_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op == 2'd3) |-> (flags_we_o == 4'b1101 && d_we_o && y_we_o && !x_we_o));
  a_r1_narrow_targets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_op == 2'd0 && !cap_zero) |-> (x_we_o && d_we_o && !y_we_o));
  a_r2_wide_targets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (cap_op == 2'd1 || cap_op == 2'd2) && !cap_zero) |->
      (y_we_o && d_we_o && !x_we_o && flags_we_o == 4'b1111));
endmodule

bind mdu_top mdu_chk #(.DW(DW)) i_mdu_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .op_i      (op_i),
  .x_i       (x_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .d_we_o    (d_we_o),
  .x_we_o    (x_we_o),
  .y_we_o    (y_we_o),
  .flags_o   (flags_o),
  .flags_we_o(flags_we_o)
);

// File: tb/test_mdu_top.sv
`timescale 1ns/1ps
module test_mdu_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] d = '0, x = '0, y = '0;
  logic        busy, done, d_we, x_we, y_we;
  logic [15:0] d_o, x_o, y_o;
  logic [3:0]  flg, flg_we;
  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  mdu_top i_mdu_top (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .op_i(op),
    .d_i(d), .x_i(x), .y_i(y),
    .busy_o(busy), .done_o(done),
    .d_o(d_o), .x_o(x_o), .y_o(y_o),
    .d_we_o(d_we), .x_we_o(x_we), .y_we_o(y_we),
    .flags_o(flg), .flags_we_o(flg_we)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // Reference model: compute expectations, then compare every cycle until done.
  task automatic run(input logic [1:0] o, input logic [15:0] dv, input logic [15:0] xv,
                     input logic [15:0] yv, input bit poke);
    longint a, b, q, r, p;
    logic [63:0] qv, rv, pv;
    logic [15:0] ed, ex, ey;
    logic [3:0]  ef, ew;
    bit ewd, ewx, ewy, vf;
    int L;
    string tg, vtg, ftg;
    ed = '0; ex = '0; ey = '0; ef = '0; ew = '0;
    ewd = 0; ewx = 0; ewy = 0;
    vtg = (o == 2'd1) ? "R5" : "R4";
    ftg = "R7";
    if (o == 2'd3) begin
      tg = "R8"; ftg = "R9";
      a = $signed(dv); b = $signed(yv);
      p = a * b; pv = p;
      ed = pv[15:0]; ey = pv[31:16]; ewd = 1; ewy = 1;
      ef = {pv[31:0] == 32'd0, pv[31], 1'b0, pv[15]};
      ew = 4'b1101; L = 1;
    end else begin
      tg = (o == 2'd0) ? "R1" : ((o == 2'd1) ? "R2" : "R3");
      if (o == 2'd0) begin a = $signed(dv); b = $signed(xv); end
      else if (o == 2'd1) begin a = {yv, dv}; b = xv; end
      else begin a = $signed({yv, dv}); b = $signed(xv); end
      if (b == 0) begin
        tg = "R6"; ftg = "R6"; vtg = "R6";
        ef = 4'b0001; ew = 4'b0001; L = 1;
      end else begin
        q = a / b; r = a % b; qv = q; rv = r;
        vf = (o == 2'd1) ? (q > 65535) : (q > 32767 || q < -32768);
        ef = {q == 0, qv[15], vf, 1'b0}; ew = 4'b1111;
        ed = rv[15:0]; ewd = 1;
        if (o == 2'd0) begin ex = qv[15:0]; ewx = 1; end
        else begin ey = qv[15:0]; ewy = 1; end
        L = 33;
      end
    end
    @(negedge clk);
    start = 1'b1; op = o; d = dv; x = xv; y = yv;
    @(posedge clk);
    @(negedge clk);
    if (poke) begin
      start = 1'b1; op = ~o; d = ~dv; x = 16'h0000; y = ~yv;
    end else start = 1'b0;
    chk(busy === 1'b1, "R11", "busy after accept", busy, 1);
    chk(done === 1'b0, "R10", "done early", done, 0);
    for (int c = 1; c <= L; c++) begin
      @(negedge clk);
      if (c == 1) start = 1'b0;
      chk(done === (c == L), "R10", "done timing", done, (c == L));
      chk(busy === (c < L), "R11", "busy timing", busy, (c < L));
      if (c < L)
        chk({d_we, x_we, y_we, flg_we} === 7'd0, "R12", "enable outside done",
            {d_we, x_we, y_we, flg_we}, 0);
    end
    chk({d_we, x_we, y_we} === {ewd, ewx, ewy}, tg, "reg enables",
        {d_we, x_we, y_we}, {ewd, ewx, ewy});
    chk(flg_we === ew, ftg, "flag enables", flg_we, ew);
    if (ewd) chk(d_o === ed, tg, "D result", d_o, ed);
    if (ewx) chk(x_o === ex, tg, "X result", x_o, ex);
    if (ewy) chk(y_o === ey, tg, "Y result", y_o, ey);
    chk((flg & ew & 4'b1101) === (ef & ew & 4'b1101), ftg, "Z/N/C flags", flg, ef);
    if (ew[1]) chk(flg[1] === ef[1], vtg, "V flag", flg[1], ef[1]);
    chk((flg & ~flg_we) === 4'b0000, "R12", "masked flags", flg, flg & flg_we);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk({busy, done} === 2'b00, "R13", "busy/done after reset", {busy, done}, 0);
    chk({d_we, x_we, y_we, flg_we} === 7'd0, "R13", "enables after reset",
        {d_we, x_we, y_we, flg_we}, 0);
    chk({d_o, x_o, y_o, flg} === 52'd0, "R13", "outputs after reset", {d_o, x_o, y_o}, 0);

    // R1 signed narrow divide, sign rules
    run(2'd0, 16'd100, 16'd7, 16'h1234, 0);
    run(2'd0, -16'sd100, 16'd7, 16'h0, 0);
    run(2'd0, 16'd100, -16'sd7, 16'h0, 0);
    run(2'd0, -16'sd100, -16'sd7, 16'h0, 0);
    run(2'd0, 16'd0, 16'd5, 16'h0, 0);
    run(2'd0, 16'h8000, 16'hFFFF, 16'h0, 0);   // R4 overflow
    run(2'd0, 16'd3, 16'd0, 16'h0, 0);         // R6
    // R2 unsigned wide divide, R5
    run(2'd1, 16'h0000, 16'd2, 16'h0001, 0);
    run(2'd1, 16'hFFFF, 16'd1, 16'hFFFF, 0);
    run(2'd1, 16'd12345, 16'hFFFF, 16'h0000, 0);
    run(2'd1, 16'h1111, 16'd0, 16'h2222, 0);   // R6
    // R3 signed wide divide, R4 bounds
    run(2'd2, 16'h7960, 16'd3, 16'hFFFE, 0);   // -100000 / 3
    run(2'd2, 16'h0000, 16'hFFFF, 16'h8000, 0);
    run(2'd2, 16'h0000, -16'sd2, 16'h0001, 0); // -32768, no V
    run(2'd2, 16'h0000, 16'd2, 16'h0001, 0);   // 32768, V
    run(2'd2, 16'h0001, 16'd0, 16'h0000, 0);   // R6
    // R8/R9 multiply
    run(2'd3, 16'd3, 16'h0, -16'sd4, 0);
    run(2'd3, 16'h8000, 16'h0, 16'h8000, 0);
    run(2'd3, 16'd0, 16'h0, 16'h1234, 0);
    run(2'd3, 16'h0100, 16'h0, 16'h0080, 0);
    // R11 start ignored while busy
    run(2'd0, -16'sd1234, 16'd10, 16'h0, 1);
    run(2'd2, 16'h4321, 16'h8000, 16'h8765, 1);
    run(2'd3, 16'h7FFF, 16'h0, 16'h7FFF, 1);
    run(2'd1, 16'hABCD, 16'h0000, 16'h0001, 1);
    // mixed patterns
    void'($urandom(17));
    for (int i = 0; i < 24; i++) begin
      logic [1:0] ro;
      logic [15:0] rd, rx, ry;
      ro = 2'($urandom); rd = 16'($urandom); rx = 16'($urandom); ry = 16'($urandom);
      if (i % 3 == 0) rx = rx & 16'h00FF;
      run(ro, rd, rx, ry, 0);
    end
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule